// File: doc/BRIEF.md
# Token-Ring Node Status and Interrupt Flags

This block keeps the status flags of a node on a token-passing LAN and drives the host interrupt. The host issues single-cycle command strobes: arm the receiver, arm the transmitter, stop the transmitter, clear flags, soft reset, and write the node address. The link engine reports its own events as single-cycle strobes: a packet has been stored, the last byte has left, an acknowledge has come back, the token has arrived, and a packet has arrived for this node. A free-running line-idle timer watches the receive line and flags a network reconfiguration after 41 microseconds without an edge.

The host reads an 8-bit status word. A mask register selects which of three flags may raise the interrupt line. While the receiver is not armed, every packet that arrives for this node is refused through a NAK request.

Top module: `tokring_status`

## Requirements
- R1: After hardware reset the status word is 0x91 (bit 7 receiver-blocked, bit 4 reset-seen, bit 0 transmitter-free all 1). The interrupt line is 0 and the mask is all zero.
- R2: Bit 7 (receiver-blocked) goes to 0 one clock after `cmd_rx_en`. It goes to 1 one clock after `ev_stored`. When both occur in the same cycle, `cmd_rx_en` wins.
- R3: Bit 4 (reset-seen) goes to 1 after a node-address write of 0x00. A write of any other value has no effect. Only `cmd_clr` clears it, and `cmd_clr` wins over a same-cycle 0x00 write.
- R4: `cmd_soft_rst` returns every flag to the R1 value one clock later and cancels any pending transmit. It takes priority over every other input. The mask is kept.
- R5: Bit 2 (reconfigured) goes to 1 about IDLE_CYC = CLK_KHZ*IDLE_US/1000 clocks after the last edge on `rx_line`. It fires once per idle period, and only a new edge re-arms it. `cmd_clr` clears it.
- R6: Bit 1 (transmit-acked) goes to 0 one clock after `cmd_tx_en`. It goes to 1 after `ev_ack` while `tx_bcast` is 0. An acknowledge while `tx_bcast` is 1 has no effect. The clear wins over a same-cycle set.
- R7: Bit 0 (transmitter-free) goes to 1 one clock after `ev_last_byte` or `cmd_tx_dis`.
- R8: Bit 0 does not clear on `cmd_tx_en` itself. It clears on the first `ev_token` after that command. A token with no pending command has no effect. `cmd_tx_dis` cancels the pending command. A token clear wins over a same-cycle set.
- R9: Status bits 6, 5 and 3 always read 0.
- R10: `nak_req` equals `pkt_in` AND bit 7, in the same cycle.
- R11: `irq` is registered and follows the flags and mask by one clock. It is high when any of (bit7 & mask[7]), (bit2 & mask[2]) or (bit0 & mask[0]) is true. `mask_wr` loads these three mask positions from `mask_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_rx_en | input | 1 | Host arms the receiver |
| cmd_tx_en | input | 1 | Host arms a transmit |
| cmd_tx_dis | input | 1 | Host stops the transmitter |
| cmd_clr | input | 1 | Host clears the reset-seen and reconfigured flags |
| cmd_soft_rst | input | 1 | Host soft reset |
| nid_wr | input | 1 | Node address write strobe |
| nid_data | input | 8 | Node address value |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_data | input | 8 | Mask value (bits 7, 2, 0 used) |
| ev_stored | input | 1 | Received packet stored in the armed page |
| ev_last_byte | input | 1 | Last byte of the scheduled packet sent |
| ev_ack | input | 1 | Acknowledge received for the sent packet |
| tx_bcast | input | 1 | Packet being sent is a broadcast |
| ev_token | input | 1 | Token received |
| rx_line | input | 1 | Receive line level |
| pkt_in | input | 1 | A packet addressed to this node is arriving |
| status | output | 8 | Status word |
| irq | output | 1 | Masked interrupt |
| nak_req | output | 1 | Refuse the incoming packet |

## Verification
Dense random strobes with collisions check the priority rules, because set and clear strobes for the same flag often land in the same cycle. Node address writes use both 0x00 and other values, so a wrong address decode shows up. Random broadcast marking separates real acknowledges from broadcast ones. Directed sequences cover the delayed transmitter clear: the command alone, then the token. A long quiet line checks the timeout window from both sides, checks that it fires only once, and checks that the mask keeps the interrupt down.

// File: rtl/tokring_status.sv
module tokring_status #(
  parameter int CLK_KHZ = 20000,
  parameter int IDLE_US = 41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_rx_en,
  input  logic       cmd_tx_en,
  input  logic       cmd_tx_dis,
  input  logic       cmd_clr,
  input  logic       cmd_soft_rst,
  input  logic       nid_wr,
  input  logic [7:0] nid_data,
  input  logic       mask_wr,
  input  logic [7:0] mask_data,
  input  logic       ev_stored,
  input  logic       ev_last_byte,
  input  logic       ev_ack,
  input  logic       tx_bcast,
  input  logic       ev_token,
  input  logic       rx_line,
  input  logic       pkt_in,
  output logic [7:0] status,
  output logic       irq,
  output logic       nak_req
);
  localparam int IDLE_CYC = CLK_KHZ * IDLE_US / 1000;
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

  logic          rx_q, armed, tmo, rx_edge;
  logic [CW-1:0] cnt;
  logic          inh, por, recon, tma, ta, pend;
  logic [2:0]    mask;

  assign rx_edge = rx_line ^ rx_q;
  assign tmo     = armed && !rx_edge && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 1'b0;
      armed <= 1'b1;
      cnt   <= '0;
    end else begin
      rx_q <= rx_line;
      if (rx_edge) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (cnt == LAST) begin
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh <= 1'b1; por <= 1'b1; recon <= 1'b0;
      tma <= 1'b0; ta  <= 1'b1; pend  <= 1'b0;
    end else if (cmd_soft_rst) begin
      inh <= 1'b1; por <= 1'b1; recon <= 1'b0;
      tma <= 1'b0; ta  <= 1'b1; pend  <= 1'b0;
    end else begin
      if (cmd_rx_en)      inh <= 1'b0;
      else if (ev_stored) inh <= 1'b1;

      if (cmd_clr)                          por <= 1'b0;
      else if (nid_wr && nid_data == 8'h00) por <= 1'b1;

      if (cmd_clr)  recon <= 1'b0;
      else if (tmo) recon <= 1'b1;

      if (cmd_tx_en)                tma <= 1'b0;
      else if (ev_ack && !tx_bcast) tma <= 1'b1;

      if (ev_token && pend)                ta <= 1'b0;
      else if (ev_last_byte || cmd_tx_dis) ta <= 1'b1;

      if (cmd_tx_en)                  pend <= 1'b1;
      else if (ev_token || cmd_tx_dis) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      if (mask_wr) mask <= {mask_data[7], mask_data[2], mask_data[0]};
      irq <= |(mask & {inh, recon, ta});
    end
  end

  assign status  = {inh, 2'b00, por, 1'b0, recon, tma, ta};
  assign nak_req = pkt_in & inh;
endmodule

module tokring_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_rx_en,
  input logic       cmd_tx_en,
  input logic       cmd_clr,
  input logic       cmd_soft_rst,
  input logic       ev_ack,
  input logic       tx_bcast,
  input logic       pkt_in,
  input logic [7:0] status,
  input logic       nak_req
);
  a_r2_rx_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_en && !cmd_soft_rst |=> !status[7]);
  a_r3_clear_drops_por: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr && !cmd_soft_rst |=> !status[4]);
  a_r5_clear_drops_recon: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr && !cmd_soft_rst |=> !status[2]);
  a_r6_tx_arm_clears_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_en && !cmd_soft_rst |=> !status[1]);
  a_r6_bcast_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack && tx_bcast && !cmd_tx_en && !cmd_soft_rst |=> status[1] == $past(status[1]));
  a_r4_soft_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_soft_rst |=> status == 8'h91);
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:5] == 2'b00 && !status[3]);
  a_r10_nak_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_in && status[7] |-> nak_req);
endmodule

bind tokring_status tokring_status_chk u_chk (.*);

// File: tb/tokring_status_tb.sv
module tokring_status_tb;
  localparam int CLK_NS = 10;
  localparam int IDLE_CYC = 20000 * 41 / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_rx_en, cmd_tx_en, cmd_tx_dis, cmd_clr, cmd_soft_rst;
  logic nid_wr, mask_wr, ev_stored, ev_last_byte, ev_ack, tx_bcast, ev_token, pkt_in;
  logic [7:0] nid_data, mask_data;
  logic rx_line = 1'b0;
  logic rx_run = 1'b1;
  logic [7:0] status;
  logic irq, nak_req;

  int total = 0, bad = 0;
  bit done = 0;
  logic m_inh, m_por, m_recon, m_tma, m_ta, m_pend;
  logic [2:0] m_mask;

  tokring_status u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;
  always @(negedge clk) if (rx_run) rx_line <= ~rx_line;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    cmd_rx_en = 0; cmd_tx_en = 0; cmd_tx_dis = 0; cmd_clr = 0; cmd_soft_rst = 0;
    nid_wr = 0; nid_data = 8'h55; mask_wr = 0; mask_data = 0;
    ev_stored = 0; ev_last_byte = 0; ev_ack = 0; tx_bcast = 0; ev_token = 0; pkt_in = 0;
  endtask

  task automatic model_reset();
    m_inh = 1; m_por = 1; m_recon = 0; m_tma = 0; m_ta = 1; m_pend = 0;
  endtask

  function automatic logic [7:0] exp_status();
    return {m_inh, 2'b00, m_por, 1'b0, m_recon, m_tma, m_ta};
  endfunction

  task automatic check_word();
    logic [7:0] e;
    e = exp_status();
    chk(status[7] == e[7], "R2 receiver-blocked", status, e);
    chk(status[4] == e[4], "R3 reset-seen", status, e);
    chk(status[2] == e[2], "R5 reconfigured", status, e);
    chk(status[1] == e[1], "R6 transmit-acked", status, e);
    chk(status[0] == e[0], "R8 transmitter-free", status, e);
    chk(status[6:5] == 2'b00 && status[3] == 1'b0, "R9 reserved bits", status, e);
  endtask

  // inputs are already driven at a negedge; check, clock, update model, check
  task automatic step();
    logic e_irq;
    #1;
    chk(nak_req == (pkt_in & m_inh), "R10 nak_req", nak_req, pkt_in & m_inh);
    e_irq = |(m_mask & {m_inh, m_recon, m_ta});
    @(posedge clk); #1;
    if (cmd_soft_rst) model_reset();
    else begin
      m_inh   = cmd_rx_en ? 1'b0 : ev_stored ? 1'b1 : m_inh;
      m_por   = cmd_clr ? 1'b0 : (nid_wr && nid_data == 8'h00) ? 1'b1 : m_por;
      m_recon = cmd_clr ? 1'b0 : m_recon;
      m_tma   = cmd_tx_en ? 1'b0 : (ev_ack && !tx_bcast) ? 1'b1 : m_tma;
      m_ta    = (ev_token && m_pend) ? 1'b0 : (ev_last_byte || cmd_tx_dis) ? 1'b1 : m_ta;
      m_pend  = cmd_tx_en ? 1'b1 : (ev_token || cmd_tx_dis) ? 1'b0 : m_pend;
    end
    if (mask_wr) m_mask = {mask_data[7], mask_data[2], mask_data[0]};
    check_word();
    chk(irq == e_irq, "R11 irq", irq, e_irq);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    model_reset();
    m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(status == 8'h91, "R1 reset status", status, 8'h91);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    @(negedge clk);

    // R8: arming the transmitter alone keeps bit 0, the token clears it
    cmd_tx_en = 1; step();
    repeat (3) step();
    chk(status[0] == 1'b1, "R8 no clear on command", status[0], 1);
    ev_token = 1; step();
    chk(status[0] == 1'b0, "R8 clear on token", status[0], 0);
    ev_token = 1; step();
    ev_last_byte = 1; step();
    ev_token = 1; step();
    chk(status[0] == 1'b1, "R8 token without pending", status[0], 1);
    // R7: transmitter stop sets bit 0 and cancels the pending clear
    cmd_tx_en = 1; step();
    ev_token = 1; step();
    cmd_tx_dis = 1; step();
    chk(status[0] == 1'b1, "R7 stop sets free", status[0], 1);
    cmd_tx_en = 1; step();
    cmd_tx_dis = 1; step();
    ev_token = 1; step();
    chk(status[0] == 1'b1, "R8 stop cancels pending", status[0], 1);
    // R6: broadcast acknowledge ignored
    ev_ack = 1; tx_bcast = 1; step();
    chk(status[1] == 1'b0, "R6 broadcast ack", status[1], 0);
    ev_ack = 1; cmd_tx_en = 1; step();
    chk(status[1] == 1'b0, "R6 clear wins", status[1], 0);
    ev_ack = 1; step();
    chk(status[1] == 1'b1, "R6 ack sets", status[1], 1);
    // R3: nonzero address write ignored; clear beats zero write
    cmd_clr = 1; step();
    nid_wr = 1; nid_data = 8'h3c; step();
    chk(status[4] == 1'b0, "R3 nonzero write", status[4], 0);
    nid_wr = 1; nid_data = 8'h00; cmd_clr = 1; step();
    chk(status[4] == 1'b0, "R3 clear wins", status[4], 0);
    nid_wr = 1; nid_data = 8'h00; step();
    chk(status[4] == 1'b1, "R3 zero write", status[4], 1);
    // R2 and R10
    cmd_rx_en = 1; ev_stored = 1; step();
    chk(status[7] == 1'b0, "R2 arm wins", status[7], 0);
    pkt_in = 1; step();
    ev_stored = 1; step();
    pkt_in = 1; step();
    // R11 masking
    mask_wr = 1; mask_data = 8'h84; step();
    step(); step();
    chk(irq == 1'b1, "R11 masked inh", irq, 1);
    cmd_rx_en = 1; step(); step();
    chk(irq == 1'b0, "R11 nothing unmasked", irq, 0);
    // R4 soft reset keeps mask
    mask_wr = 1; mask_data = 8'h01; step();
    cmd_tx_en = 1; step();
    cmd_soft_rst = 1; cmd_clr = 1; ev_ack = 1; step();
    chk(status == 8'h91, "R4 soft reset", status, 8'h91);
    ev_token = 1; step(); step();
    chk(irq == 1'b1, "R4 mask kept, pend cancelled", irq, 1);

    // R5: quiet line
    rx_run = 0;
    @(negedge clk);
    for (int i = 0; i < IDLE_CYC - 6; i++) step();
    chk(status[2] == 1'b0, "R5 not early", status[2], 0);
    repeat (10) @(posedge clk);
    #1;
    chk(status[2] == 1'b1, "R5 timeout", status[2], 1);
    m_recon = 1;
    @(negedge clk);
    cmd_clr = 1; step();
    for (int i = 0; i < IDLE_CYC + 20; i++) step();
    chk(status[2] == 1'b0, "R5 one-shot", status[2], 0);
    rx_run = 1;
    step(); step();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cmd_rx_en    = ($urandom % 8) == 0;
      cmd_tx_en    = ($urandom % 8) == 0;
      cmd_tx_dis   = ($urandom % 16) == 0;
      cmd_clr      = ($urandom % 10) == 0;
      cmd_soft_rst = ($urandom % 60) == 0;
      nid_wr       = ($urandom % 8) == 0;
      nid_data     = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom);
      mask_wr      = ($urandom % 12) == 0;
      mask_data    = 8'($urandom);
      ev_stored    = ($urandom % 6) == 0;
      ev_last_byte = ($urandom % 7) == 0;
      ev_ack       = ($urandom % 5) == 0;
      tx_bcast     = ($urandom % 2) == 0;
      ev_token     = ($urandom % 4) == 0;
      pkt_in       = ($urandom % 3) == 0;
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule